// File: doc/BRIEF.md
# Polyphase FIR Interpolator

This block raises the sample rate of a signed data stream by a fixed integer factor. For every sample taken in at the low rate, it produces FACTOR filtered samples at the high rate. The result is the same as padding each input with FACTOR-1 zeros and running the padded stream through a TAPS-tap FIR. The padding is never built, and no product with a padded zero is ever formed.

The prototype coefficient set is split into FACTOR sub-filters. Sub-filter k holds every FACTOR-th coefficient, starting at index k. All sub-filters read one shared history of the last TAPS/FACTOR input samples, which changes only when a new input is accepted. A phase counter then walks through the sub-filter results, one per cycle, to build the high-rate stream. Each selected sum is rounded and saturated to the output width.

Input uses a valid/ready handshake, and ready stays low while a burst is being emitted. Output is a valid/data pair with no back-pressure. The coefficients are a parameter vector in which entry j sits at bits j*COEF_W and is a signed fixed-point value with FRAC_BITS fraction bits.

Top module: `poly_interp`

## Requirements
- R1: While reset (rst_n low, sampled on the clock edge) is applied and in the first cycle after it, out_valid is 0 and in_ready is 1.
- R2: An input accepted on a clock edge (in_valid and in_ready both 1) yields out_valid = 1 on exactly the next FACTOR cycles, and out_valid = 0 in the cycle after them.
- R3: in_ready is 0 on every cycle in which out_valid is 1. An input offered then is not taken, and the sample history does not change.
- R4: For the n-th accepted input (n counted from 0 since reset), the k-th output of its burst (k = 0..FACTOR-1, in that order) equals output number n*FACTOR+k of a TAPS-tap FIR applied to the zero-padded stream.
- R5: Output k of a burst is the sum over i of h[i*FACTOR+k] times the input accepted i samples earlier, where i = 0 is the newest input.
- R6: Sums are kept at full precision and then rounded by adding 2^(FRAC_BITS-1) and shifting right arithmetically by FRAC_BITS.
- R7: A rounded result above 2^(DATA_W-1)-1 is output as 2^(DATA_W-1)-1. One below -2^(DATA_W-1) is output as -2^(DATA_W-1).
- R8: With no input accepted, out_valid stays 0.
- R9: A reset in the middle of a stream clears the sample history, so later outputs behave as if every earlier input were zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take an input this cycle |
| in_data | input | DATA_W | Signed low-rate input sample |
| out_valid | output | 1 | out_data holds a high-rate sample |
| out_data | output | DATA_W | Signed high-rate output sample |

## Verification
The coefficient set used in testing is asymmetric. An impulse therefore shows at once any design that swaps sub-filters, reverses the history, or emits the branches out of order. Full-scale inputs of both signs drive two branch sums past the output range. A missing or one-sided clamp would wrap those outputs to the opposite sign. In some bursts, in_valid is held high with junk data during emission. A design that does not apply back-pressure would take the junk, lengthen the burst, and corrupt every later expected value. A reset in mid-stream followed by an impulse exposes any history that survives reset, because stale samples would appear in the impulse response.

// File: rtl/poly_pkg.sv
// Shared width helpers for the polyphase interpolator.
// Assumes all arguments are positive.
package poly_pkg;

    // Full-precision accumulator width for a sum of `terms` products.
    function automatic int acc_width(input int dw, input int cw, input int terms);
        return dw + cw + $clog2(terms) + 1;
    endfunction

    // Width of a counter that indexes `n` entries (at least one bit).
    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/poly_delay_line.sv
// Low-rate sample history shared by every sub-filter.
// Slot 0 (lowest bits) holds the newest sample. The line shifts only on shift_en.
// Assumes DEPTH >= 1.
module poly_delay_line #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     shift_en,
    input  logic [DATA_W-1:0]        din,
    output logic [DEPTH*DATA_W-1:0]  taps
);

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        if (s == 0) begin : g_head
            // Newest slot loads the accepted sample.
            always_ff @(posedge clk) begin
                if (!rst_n)        taps[DATA_W-1:0] <= '0;
                else if (shift_en) taps[DATA_W-1:0] <= din;
            end
        end else begin : g_body
            // Older slots take their younger neighbour.
            always_ff @(posedge clk) begin
                if (!rst_n)        taps[s*DATA_W +: DATA_W] <= '0;
                else if (shift_en) taps[s*DATA_W +: DATA_W] <= taps[(s-1)*DATA_W +: DATA_W];
            end
        end
    end

endmodule

// File: rtl/poly_branch.sv
// One polyphase sub-filter: a full-precision dot product of the shared history
// with this branch's coefficient slice. Purely combinational.
// Assumes ACC_W is wide enough for DEPTH products (see poly_pkg::acc_width).
module poly_branch #(
    parameter int DATA_W = 16,
    parameter int COEF_W = 16,
    parameter int DEPTH  = 4,
    parameter int ACC_W  = 35
) (
    input  logic [DEPTH*DATA_W-1:0]  taps,
    input  logic [DEPTH*COEF_W-1:0]  coefs,
    output logic signed [ACC_W-1:0]  acc
);

    localparam int PROD_W = DATA_W + COEF_W;

    // Sum the sign-extended products over all history slots.
    always_comb begin
        logic signed [DATA_W-1:0] smp;
        logic signed [COEF_W-1:0] cof;
        logic signed [PROD_W-1:0] prod;
        acc = '0;
        for (int i = 0; i < DEPTH; i++) begin
            smp  = taps[i*DATA_W +: DATA_W];
            cof  = coefs[i*COEF_W +: COEF_W];
            prod = smp * cof;
            acc  = acc + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
        end
    end

endmodule

// File: rtl/poly_round_sat.sv
// Rounds a full-precision sum (half up, arithmetic shift by FRAC_BITS) and
// clamps it to the signed output range. Assumes FRAC_BITS >= 1 and ACC_W > OUT_W + FRAC_BITS.
module poly_round_sat #(
    parameter int ACC_W     = 35,
    parameter int OUT_W     = 16,
    parameter int FRAC_BITS = 15
) (
    input  logic signed [ACC_W-1:0] acc,
    output logic signed [OUT_W-1:0] y
);

    localparam logic signed [ACC_W:0] HALF = (ACC_W+1)'(1) <<< (FRAC_BITS-1);
    localparam logic signed [ACC_W:0] MAXV = (ACC_W+1)'((2**(OUT_W-1)) - 1);
    localparam logic signed [ACC_W:0] MINV = -MAXV - (ACC_W+1)'(1);

    logic signed [ACC_W:0] biased;
    logic signed [ACC_W:0] shifted;

    // Add the rounding bias, drop the fraction, then clamp.
    always_comb begin
        biased  = $signed({acc[ACC_W-1], acc}) + HALF;
        shifted = biased >>> FRAC_BITS;
        if (shifted > MAXV)      y = MAXV[OUT_W-1:0];
        else if (shifted < MINV) y = MINV[OUT_W-1:0];
        else                     y = shifted[OUT_W-1:0];
    end

endmodule

// File: rtl/poly_commutator.sv
// Burst controller: on an accepted input it emits FACTOR high-rate slots,
// stepping the branch index 0..FACTOR-1, and holds off input meanwhile.
// Assumes FACTOR >= 1.
module poly_commutator #(
    parameter int FACTOR  = 4,
    parameter int PHASE_W = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    output logic               in_ready,
    output logic               accept,
    output logic               out_valid,
    output logic [PHASE_W-1:0] phase
);

    logic busy;
    logic last;

    assign last      = (phase == PHASE_W'(FACTOR - 1));
    assign in_ready  = !busy;
    assign accept    = in_valid && !busy;
    assign out_valid = busy;

    // Start a burst on accept, advance the branch index, finish at the last branch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            phase <= '0;
        end else if (accept) begin
            busy  <= 1'b1;
            phase <= '0;
        end else if (busy) begin
            busy  <= !last;
            phase <= last ? '0 : phase + PHASE_W'(1);
        end
    end

    property p_start;
        @(posedge clk) disable iff (!rst_n) accept |=> (out_valid && phase == '0);
    endproperty
    assert_burst_start_R2: assert property (p_start);

    property p_step;
        @(posedge clk) disable iff (!rst_n)
            (out_valid && !last) |=> (out_valid && phase == PHASE_W'($past(phase) + 1'b1));
    endproperty
    assert_burst_step_R2: assert property (p_step);

    property p_end;
        @(posedge clk) disable iff (!rst_n) (out_valid && last) |=> !out_valid;
    endproperty
    assert_burst_end_R2: assert property (p_end);

    property p_idle;
        @(posedge clk) disable iff (!rst_n) (!out_valid && !in_valid) |=> !out_valid;
    endproperty
    assert_idle_quiet_R8: assert property (p_idle);

endmodule

// File: rtl/poly_interp.sv
// Polyphase FIR interpolator top. It splits the TAPS-tap prototype into FACTOR
// sub-filters over one shared low-rate history and emits their results in branch
// order, one per cycle, after each accepted input.
// Assumes TAPS is a multiple of FACTOR. COEFS entry j sits at bits j*COEF_W and has FRAC_BITS fraction bits.
module poly_interp #(
    parameter int FACTOR    = 4,
    parameter int TAPS      = 16,
    parameter int DATA_W    = 16,
    parameter int COEF_W    = 16,
    parameter int FRAC_BITS = 15,
    parameter logic [TAPS*COEF_W-1:0] COEFS = {
        16'shFE70, 16'shFC7C, 16'sh0000, 16'sh09C4,
        16'sh1A90, 16'sh2EE0, 16'sh4074, 16'sh4A38,
        16'sh4A38, 16'sh4074, 16'sh2EE0, 16'sh1A90,
        16'sh09C4, 16'sh0000, 16'shFC7C, 16'shFE70}
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    output logic                     in_ready,
    input  logic signed [DATA_W-1:0] in_data,
    output logic                     out_valid,
    output logic signed [DATA_W-1:0] out_data
);

    localparam int PHASES  = TAPS / FACTOR;
    localparam int ACC_W   = poly_pkg::acc_width(DATA_W, COEF_W, PHASES);
    localparam int PHASE_W = poly_pkg::idx_width(FACTOR);

    logic                      accept;
    logic [PHASE_W-1:0]        phase;
    logic [PHASES*DATA_W-1:0]  hist;
    logic signed [ACC_W-1:0]   branch_acc [FACTOR];
    logic signed [ACC_W-1:0]   acc_sel;

    poly_commutator #(.FACTOR(FACTOR), .PHASE_W(PHASE_W)) u_comm (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .accept    (accept),
        .out_valid (out_valid),
        .phase     (phase)
    );

    poly_delay_line #(.DATA_W(DATA_W), .DEPTH(PHASES)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_data),
        .taps     (hist)
    );

    for (genvar k = 0; k < FACTOR; k++) begin : g_branch
        logic [PHASES*COEF_W-1:0] sub_coef;
        for (genvar i = 0; i < PHASES; i++) begin : g_pick
            assign sub_coef[i*COEF_W +: COEF_W] = COEFS[(i*FACTOR + k)*COEF_W +: COEF_W];
        end
        poly_branch #(.DATA_W(DATA_W), .COEF_W(COEF_W), .DEPTH(PHASES), .ACC_W(ACC_W)) u_br (
            .taps  (hist),
            .coefs (sub_coef),
            .acc   (branch_acc[k])
        );
    end

    // Select the branch for the current high-rate slot.
    always_comb acc_sel = branch_acc[phase];

    poly_round_sat #(.ACC_W(ACC_W), .OUT_W(DATA_W), .FRAC_BITS(FRAC_BITS)) u_rs (
        .acc (acc_sel),
        .y   (out_data)
    );

    localparam logic signed [ACC_W-1:0] ONE     = ACC_W'(1);
    localparam logic signed [ACC_W-1:0] SAT_HI  = (ONE <<< (DATA_W-1+FRAC_BITS)) - (ONE <<< (FRAC_BITS-1));
    localparam logic signed [ACC_W-1:0] SAT_LO  = -(ONE <<< (DATA_W-1+FRAC_BITS)) - (ONE <<< (FRAC_BITS-1));
    localparam logic signed [DATA_W-1:0] OUT_MAX = {1'b0, {(DATA_W-1){1'b1}}};
    localparam logic signed [DATA_W-1:0] OUT_MIN = {1'b1, {(DATA_W-1){1'b0}}};

    property p_hold_hist;
        @(posedge clk) disable iff (!rst_n) !in_ready |=> $stable(hist);
    endproperty
    assert_hold_history_R3: assert property (p_hold_hist);

    property p_sat_hi;
        @(posedge clk) disable iff (!rst_n) (out_valid && acc_sel >= SAT_HI) |-> out_data == OUT_MAX;
    endproperty
    assert_clamp_high_R7: assert property (p_sat_hi);

    property p_sat_lo;
        @(posedge clk) disable iff (!rst_n) (out_valid && acc_sel < SAT_LO) |-> out_data == OUT_MIN;
    endproperty
    assert_clamp_low_R7: assert property (p_sat_lo);

endmodule

// File: tb/tb_poly_interp.sv
// Self-checking bench: directed impulse, saturation, back-pressure and reset
// cases plus seeded random samples, compared against a zero-padding FIR model.
module tb_poly_interp;

    localparam int D  = 4;
    localparam int L  = 16;
    localparam int DW = 16;
    localparam int CW = 16;
    localparam int SH = 15;

    localparam logic signed [CW-1:0] HC [L] = '{
        16'sd30000, -16'sd4000, 16'sd12000, 16'sd25000,
        16'sd20000, 16'sd6000, -16'sd32768, 16'sd18000,
        -16'sd3000, 16'sd1500, 16'sd9000, -16'sd7000,
        16'sd9000, 16'sd500, -16'sd2000, 16'sd32767};

    function automatic logic [L*CW-1:0] pack_coefs();
        logic [L*CW-1:0] v;
        for (int j = 0; j < L; j++) v[j*CW +: CW] = HC[j];
        return v;
    endfunction

    localparam logic [L*CW-1:0] CV = pack_coefs();

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic signed [DW-1:0] in_data = '0;
    logic out_valid;
    logic signed [DW-1:0] out_data;

    int compared = 0;
    int mismatched = 0;
    int xs [$];

    always #5 clk = ~clk;

    poly_interp #(.FACTOR(D), .TAPS(L), .DATA_W(DW), .COEF_W(CW), .FRAC_BITS(SH), .COEFS(CV)) dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data));

    task automatic check(input string rq, input longint act, input longint expv);
        compared++;
        if (act != expv) begin
            mismatched++;
            $display("FAIL %s actual=%0d expected=%0d", rq, act, expv);
        end
    endtask

    // Zero-padded stream value at high-rate index t.
    function automatic longint padded(input int t);
        if (t < 0 || (t % D) != 0) return 0;
        return longint'(xs[t / D]);
    endfunction

    // Reference: full TAPS-tap filter over the padded stream, then round and clamp.
    function automatic longint model(input int m);
        longint acc = 0;
        longint r;
        for (int j = 0; j < L; j++) acc += longint'(HC[j]) * padded(m - j);
        r = (acc + (longint'(1) <<< (SH - 1))) >>> SH;
        if (r > 32767) r = 32767;
        if (r < -32768) r = -32768;
        return r;
    endfunction

    // Offer one sample, check its whole burst, optionally hold valid with junk.
    task automatic send(input logic signed [DW-1:0] x, input bit hold, input string rq);
        int n;
        @(negedge clk);
        check("R3 ready before offer", in_ready, 1);
        in_valid = 1'b1;
        in_data  = x;
        xs.push_back(int'(x));
        n = xs.size() - 1;
        for (int k = 0; k < D; k++) begin
            @(negedge clk);
            check("R2 out_valid in burst", out_valid, 1);
            check("R3 ready low in burst", in_ready, 0);
            check(rq, out_data, model(n * D + k));
            if (k == 0 && hold) in_data = DW'($urandom);
            else if (k == 0)    in_valid = 1'b0;
            if (k == D - 1)     in_valid = 1'b0;
        end
        @(negedge clk);
        check("R2 out_valid after burst", out_valid, 0);
        check("R3 ready after burst", in_ready, 1);
    endtask

    task automatic idle(input int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            check("R8 idle no output", out_valid, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 in_ready in reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid after reset", out_valid, 0);
        check("R1 in_ready after reset", in_ready, 1);
        idle(3);

        // R5: impulse exposes coefficient-to-branch mapping and order.
        send(16'sd16384, 1'b0, "R5 impulse");
        for (int z = 0; z < 4; z++) send(16'sd0, 1'b0, "R5 impulse tail");

        // R7: full-scale positive and negative drive the clamp.
        for (int z = 0; z < 5; z++) send(16'sd32767, 1'b0, "R7 positive clamp");
        for (int z = 0; z < 5; z++) send(-16'sd32768, 1'b1, "R7 negative clamp");

        // R6: small values where rounding decides the result.
        send(16'sd1, 1'b0, "R6 rounding");
        send(-16'sd1, 1'b0, "R6 rounding");
        send(16'sd3, 1'b1, "R6 rounding");

        // R4 and R3: seeded random samples, gaps and held valid.
        for (int s = 0; s < 80; s++) begin
            logic signed [DW-1:0] x;
            x = (s % 3 == 0) ? DW'($signed($urandom_range(0, 511)) - 256) : DW'($urandom);
            send(x, 1'($urandom_range(0, 1)), "R4 random");
            if ($urandom_range(0, 3) == 0) idle(int'($urandom_range(1, 3)));
        end

        // R9: reset mid-stream, then an impulse must show no stale history.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 out_valid in mid reset", out_valid, 0);
        rst_n = 1'b1;
        xs.delete();
        @(negedge clk);
        check("R9 ready after mid reset", in_ready, 1);
        send(-16'sd20000, 1'b0, "R9 history cleared");
        for (int z = 0; z < 4; z++) send(16'sd0, 1'b0, "R9 history cleared");
        idle(2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule